// File: doc/BRIEF.md
# Banked Per-Level Register File

This block holds the general registers for a processor that runs five program levels. There are 40 registers of 22 bits, split into five groups of eight, and each program level owns one group. The block also holds a carry flag and a zero flag for each level. Whatever drives the level choice presents the active level on `act_lvl`. The block then shows the eight registers of that level's group on the working read bus. A working write always lands in that same group. When an interrupt raises a different level, the new level sees its own registers and its own flags. The registers of the interrupted level stay as they were, so software does not have to save them.

A second, external port reaches any of the 40 registers by absolute address. Control code uses it to inspect or set up the groups of levels that are not running. Each register is split into a 6-bit upper extension field (bits 21:16) and a 16-bit low part. This port moves only the low part: reads return the extension field as zero, and writes leave it untouched. Register 0 of every group is also that level's instruction address. The block brings it out on a port of its own.

The block is not a state machine. It is a flop array, a level-to-group decoder and a bank of per-level flag latches. The block has no internal sequencing states, so it has no state transitions to name.

Top module: `banked_regfile`

## Requirements
- R1: Level 1 selects group 4, which is absolute addresses 0x20–0x27. A level L from 2 to 5 selects group L-2, which starts at address 8*(L-2). Working slot k of the active level is the register at that group's base address plus k. Slot k occupies bits [22k+21:22k] of `wk_rdata`.
- R2: When `wk_we` is high at a rising clock edge, the full 22-bit `wk_wdata` goes into slot `wk_idx` of the active group. No other register changes. Register contents survive any number of level switches.
- R3: `iar_q` always equals working slot 0 of the active level.
- R4: When `flag_we` is high at a rising edge, `flag_c_in` and `flag_z_in` go into the active level's C and Z latches. `flag_c` and `flag_z` show the new values from the cycle after that edge.
- R5: A level's C and Z latches change only on an edge where `flag_we` is high while that level is active. Each level keeps its own pair, and `flag_c`/`flag_z` show the active level's pair.
- R6: `ext_rdata` returns bits 15:0 of the register at absolute address `ext_addr` (0 to 39). Bits 21:16 of `ext_rdata` are always zero.
- R7: An external write (`ext_we` high at an edge) replaces bits 15:0 of the addressed register with `ext_wdata[15:0]`. Bits 21:16 keep their old value, whatever `ext_wdata[21:16]` holds.
- R8: If a working write and an external write target the same register in one cycle, the working write's full value is stored and the external write is dropped. If they target different registers, both take effect.
- R9: During a write cycle, `wk_rdata`, `iar_q` and `ext_rdata` already show the value being written to the register they present. This follows the priority of R8.
- R10: An `act_lvl` of 0, 6 or 7 is invalid. While it is applied, `wk_rdata`, `iar_q`, `flag_c` and `flag_z` read zero, and `wk_we` and `flag_we` change no register or flag.
- R11: An `ext_addr` from 40 to 63 reads as zero, and a write to it changes no register.
- R12: While `rst_n` is low, all 40 registers and all ten flags are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| act_lvl | input | 3 | Active program level, 1 to 5 |
| wk_we | input | 1 | Working-register write strobe |
| wk_idx | input | 3 | Working slot to write |
| wk_wdata | input | 22 | Working write data |
| wk_rdata | output | 176 | All eight working slots of the active group, slot k at bits 22k+21:22k |
| iar_q | output | 22 | Instruction address of the active level (slot 0) |
| flag_we | input | 1 | Flag write strobe for the active level |
| flag_c_in | input | 1 | New carry value |
| flag_z_in | input | 1 | New zero value |
| flag_c | output | 1 | Carry latch of the active level |
| flag_z | output | 1 | Zero latch of the active level |
| ext_we | input | 1 | External write strobe |
| ext_addr | input | 6 | Absolute register address |
| ext_wdata | input | 22 | External write data; bits 21:16 are ignored |
| ext_rdata | output | 22 | External read data; bits 21:16 read zero |

## Verification
Two situations are hard to reach from the ports: a working write and an external write that land on the same register in the same cycle, and the contents of groups whose level is not active. For the collision, the bench fixes a level, picks a working slot, and sets the external address to that slot's absolute address from the rotated mapping. It then checks the bypassed read in that cycle and the stored value afterwards. For the inactive groups, every level writes distinct patterns with upper fields set. The bench then sweeps all 40 absolute addresses through the external port and revisits every level. This confirms that nothing leaked between groups, including after writes at invalid levels and to unmapped addresses.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int RF_WIDTH  = 22;
    localparam int RF_XBITS  = 6;
    localparam int RF_LEVELS = 5;
    localparam int RF_GROUP  = 8;
endpackage

// File: rtl/rf_lvl_map.sv
// Rotated level-to-group decode: level 1 owns the last group.
module rf_lvl_map #(
    parameter int LEVELS = 5,
    parameter int GROUP  = 8,
    parameter int AW     = 6,
    parameter int LW     = 3
) (
    input  logic [LW-1:0] lvl,
    output logic          valid,
    output logic [AW-1:0] base
);
    always_comb begin
        valid = (lvl >= LW'(1)) && (lvl <= LW'(LEVELS));
        if (lvl == LW'(1)) begin
            base = AW'((LEVELS - 1) * GROUP);
        end else if (valid) begin
            base = AW'((int'(lvl) - 2) * GROUP);
        end else begin
            base = '0;
        end
    end
endmodule

// File: rtl/rf_flag_bank.sv
// One carry/zero latch pair per program level.
module rf_flag_bank #(
    parameter int LEVELS = 5,
    parameter int LW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lvl,
    input  logic          valid,
    input  logic          we,
    input  logic          c_in,
    input  logic          z_in,
    output logic          c_out,
    output logic          z_out
);
    logic [LEVELS-1:0] c_q;
    logic [LEVELS-1:0] z_q;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_q[l] <= 1'b0;
                z_q[l] <= 1'b0;
            end else if (we && valid && (lvl == LW'(l + 1))) begin
                c_q[l] <= c_in;
                z_q[l] <= z_in;
            end
        end
    end

    always_comb begin
        c_out = 1'b0;
        z_out = 1'b0;
        for (int l = 0; l < LEVELS; l++) begin
            if (valid && (lvl == LW'(l + 1))) begin
                c_out = c_q[l];
                z_out = z_q[l];
            end
        end
    end
endmodule

// File: rtl/rf_store.sv
// Flat register array; view[] is the post-write value (write-through).
module rf_store #(
    parameter int WIDTH = 22,
    parameter int XBITS = 6,
    parameter int NREG  = 40,
    parameter int AW    = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wk_we,
    input  logic [AW-1:0]               wk_addr,
    input  logic [WIDTH-1:0]            wk_wdata,
    input  logic                        ext_we,
    input  logic [AW-1:0]               ext_addr,
    input  logic [WIDTH-1:0]            ext_wdata,
    output logic [NREG-1:0][WIDTH-1:0]  view
);
    localparam logic [WIDTH-1:0] XMASK = {{XBITS{1'b1}}, {(WIDTH - XBITS){1'b0}}};

    logic [NREG-1:0][WIDTH-1:0] q;

    for (genvar e = 0; e < NREG; e++) begin : g_ent
        // working write has priority over the external port
        assign view[e] = (wk_we && (wk_addr == AW'(e)))   ? wk_wdata :
                         (ext_we && (ext_addr == AW'(e))) ? ((q[e] & XMASK) | (ext_wdata & ~XMASK)) :
                                                            q[e];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= view;
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int WIDTH  = RF_WIDTH,
    parameter int XBITS  = RF_XBITS,
    parameter int LEVELS = RF_LEVELS,
    parameter int GROUP  = RF_GROUP,
    localparam int NREG  = LEVELS * GROUP,
    localparam int AW    = $clog2(NREG),
    localparam int IW    = $clog2(GROUP),
    localparam int LW    = $clog2(LEVELS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LW-1:0]            act_lvl,
    input  logic                     wk_we,
    input  logic [IW-1:0]            wk_idx,
    input  logic [WIDTH-1:0]         wk_wdata,
    output logic [GROUP*WIDTH-1:0]   wk_rdata,
    output logic [WIDTH-1:0]         iar_q,
    input  logic                     flag_we,
    input  logic                     flag_c_in,
    input  logic                     flag_z_in,
    output logic                     flag_c,
    output logic                     flag_z,
    input  logic                     ext_we,
    input  logic [AW-1:0]            ext_addr,
    input  logic [WIDTH-1:0]         ext_wdata,
    output logic [WIDTH-1:0]         ext_rdata
);
    localparam logic [WIDTH-1:0] LOW_MASK = {{XBITS{1'b0}}, {(WIDTH - XBITS){1'b1}}};

    logic                       lvl_ok;
    logic [AW-1:0]              grp_base;
    logic [AW-1:0]              wk_addr;
    logic [NREG-1:0][WIDTH-1:0] view;
    logic                       ext_in;
    logic [WIDTH-1:0]           ext_sel;

    rf_lvl_map #(.LEVELS(LEVELS), .GROUP(GROUP), .AW(AW), .LW(LW)) map_i (
        .lvl   (act_lvl),
        .valid (lvl_ok),
        .base  (grp_base)
    );

    assign wk_addr = grp_base + AW'(wk_idx);

    rf_store #(.WIDTH(WIDTH), .XBITS(XBITS), .NREG(NREG), .AW(AW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wk_we     (wk_we && lvl_ok),
        .wk_addr   (wk_addr),
        .wk_wdata  (wk_wdata),
        .ext_we    (ext_we),
        .ext_addr  (ext_addr),
        .ext_wdata (ext_wdata),
        .view      (view)
    );

    rf_flag_bank #(.LEVELS(LEVELS), .LW(LW)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (act_lvl),
        .valid (lvl_ok),
        .we    (flag_we),
        .c_in  (flag_c_in),
        .z_in  (flag_z_in),
        .c_out (flag_c),
        .z_out (flag_z)
    );

    for (genvar k = 0; k < GROUP; k++) begin : g_slot
        assign wk_rdata[k*WIDTH +: WIDTH] = lvl_ok ? view[grp_base + AW'(k)] : '0;
    end

    assign iar_q     = wk_rdata[WIDTH-1:0];
    assign ext_in    = ext_addr < AW'(NREG);
    assign ext_sel   = ext_in ? view[ext_addr] : '0;
    assign ext_rdata = ext_sel & LOW_MASK;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import rf_pkg::*;
#(
    parameter int WIDTH  = RF_WIDTH,
    parameter int XBITS  = RF_XBITS,
    parameter int LEVELS = RF_LEVELS,
    parameter int GROUP  = RF_GROUP,
    localparam int NREG  = LEVELS * GROUP,
    localparam int AW    = $clog2(NREG),
    localparam int IW    = $clog2(GROUP),
    localparam int LW    = $clog2(LEVELS + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LW-1:0]          act_lvl,
    input logic                   wk_we,
    input logic [IW-1:0]          wk_idx,
    input logic [WIDTH-1:0]       wk_wdata,
    input logic [GROUP*WIDTH-1:0] wk_rdata,
    input logic [WIDTH-1:0]       iar_q,
    input logic                   flag_we,
    input logic                   flag_c_in,
    input logic                   flag_z_in,
    input logic                   flag_c,
    input logic                   flag_z,
    input logic                   ext_we,
    input logic [AW-1:0]          ext_addr,
    input logic [WIDTH-1:0]       ext_wdata,
    input logic [WIDTH-1:0]       ext_rdata
);
    logic lvl_good;
    assign lvl_good = (act_lvl != '0) && (act_lvl <= LW'(LEVELS));

    a_r3_iar_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        iar_q == wk_rdata[WIDTH-1:0]);

    a_r6_ext_x_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rdata[WIDTH-1:WIDTH-XBITS] == '0);

    a_r10_bad_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_good |-> (wk_rdata == '0 && !flag_c && !flag_z));

    a_r4_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && lvl_good) |=> (act_lvl != $past(act_lvl)) ||
            (flag_c == $past(flag_c_in) && flag_z == $past(flag_z_in)));

    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |=> (act_lvl != $past(act_lvl)) ||
            (flag_c == $past(flag_c) && flag_z == $past(flag_z)));

    a_r2_group_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wk_we && !ext_we) |=> (act_lvl != $past(act_lvl)) || wk_we || ext_we ||
            (wk_rdata == $past(wk_rdata)));
endmodule

bind banked_regfile rf_checker #(
    .WIDTH(WIDTH), .XBITS(XBITS), .LEVELS(LEVELS), .GROUP(GROUP)
) chk_i (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
    localparam int W = 22;
    localparam int G = 8;
    localparam int N = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    act_lvl;
    logic          wk_we;
    logic [2:0]    wk_idx;
    logic [W-1:0]  wk_wdata;
    logic [G*W-1:0] wk_rdata;
    logic [W-1:0]  iar_q;
    logic          flag_we, flag_c_in, flag_z_in, flag_c, flag_z;
    logic          ext_we;
    logic [5:0]    ext_addr;
    logic [W-1:0]  ext_wdata;
    logic [W-1:0]  ext_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] mdl [N];
    bit mc [5];
    bit mz [5];

    always #2.5 clk = ~clk;

    banked_regfile dut_i (
        .clk, .rst_n, .act_lvl, .wk_we, .wk_idx, .wk_wdata, .wk_rdata, .iar_q,
        .flag_we, .flag_c_in, .flag_z_in, .flag_c, .flag_z,
        .ext_we, .ext_addr, .ext_wdata, .ext_rdata
    );

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int base_of(int l);
        return (l == 1 ? 4 : l - 2) * G;
    endfunction

    function automatic logic [W-1:0] pat(int l, int i);
        return W'((l * 7 + i + 1) << 16) ^ W'(l * 4099 + i * 263 + 17);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        wk_we = 0; flag_we = 0; ext_we = 0;
        wk_idx = '0; wk_wdata = '0; flag_c_in = 0; flag_z_in = 0;
        ext_addr = '0; ext_wdata = '0;
    endtask

    task automatic read_all(string req);
        for (int a = 0; a < N; a++) begin
            ext_addr = 6'(a);
            #0.5;
            check(req, ext_rdata, {6'b0, mdl[a][15:0]});
        end
    endtask

    task automatic check_level(int l, string req);
        act_lvl = 3'(l);
        #0.5;
        for (int k = 0; k < G; k++) check(req, wk_rdata[k*W +: W], mdl[base_of(l) + k]);
        check({req, " iar R3"}, iar_q, mdl[base_of(l)]);
    endtask

    task automatic check_flags(string req);
        for (int l = 1; l <= 5; l++) begin
            act_lvl = 3'(l);
            #0.5;
            check({req, " C"}, W'(flag_c), W'(mc[l-1]));
            check({req, " Z"}, W'(flag_z), W'(mz[l-1]));
        end
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        rst_n = 0; act_lvl = 3'd2; idle();
        for (int a = 0; a < N; a++) mdl[a] = '0;
        for (int l = 0; l < 5; l++) begin mc[l] = 0; mz[l] = 0; end
        repeat (3) @(posedge clk);
        #1;
        // R12: reset state
        read_all("R12 reset regs");
        check_flags("R12 reset flags");
        rst_n = 1;
        tick();

        // R2/R9: every level writes all slots; bypass visible before edge
        for (int l = 1; l <= 5; l++) begin
            for (int i = 0; i < G; i++) begin
                act_lvl = 3'(l); wk_idx = 3'(i); wk_wdata = pat(l, i); wk_we = 1;
                #0.5;
                check("R9 wk bypass", wk_rdata[i*W +: W], pat(l, i));
                tick();
                wk_we = 0;
                mdl[base_of(l) + i] = pat(l, i);
            end
        end
        // R1/R6: rotated mapping via absolute addresses
        read_all("R1 R6 map");
        // R2/R3: each group intact after all level switches
        for (int l = 5; l >= 1; l--) check_level(l, "R2 persist");

        // R7: external writes keep upper field; R9 external bypass
        for (int a = 0; a < N; a++) begin
            v = {6'h3F ^ 6'(a), 16'(a * 977 + 5)};
            ext_we = 1; ext_addr = 6'(a); ext_wdata = v;
            #0.5;
            check("R9 ext bypass", ext_rdata, {6'b0, v[15:0]});
            tick();
            ext_we = 0;
            mdl[a] = {mdl[a][21:16], v[15:0]};
        end
        for (int l = 1; l <= 5; l++) check_level(l, "R7 x kept");

        // R8: same-register collision (level 3 slot 5 = addr 0x0D)
        act_lvl = 3'd3; wk_idx = 3'd5; wk_wdata = 22'h2A5A5A; wk_we = 1;
        ext_addr = 6'h0D; ext_wdata = 22'h01FFFF; ext_we = 1;
        #0.5;
        check("R8 R9 collision bypass", ext_rdata, 22'h005A5A);
        tick();
        idle();
        mdl[13] = 22'h2A5A5A;
        check_level(3, "R8 collision wk wins");
        // R8: different registers both written (level 4 slot 0 = 0x10, ext 0x11)
        act_lvl = 3'd4; wk_idx = 3'd0; wk_wdata = 22'h155555; wk_we = 1;
        ext_addr = 6'h11; ext_wdata = 22'h00BEEF; ext_we = 1;
        tick();
        idle();
        mdl[16] = 22'h155555;
        mdl[17] = {mdl[17][21:16], 16'hBEEF};
        check_level(4, "R8 disjoint both");

        // R4: flag load for every level and combination
        for (int l = 1; l <= 5; l++) begin
            act_lvl = 3'(l);
            for (int c = 0; c < 4; c++) begin
                flag_we = 1; flag_c_in = c[0]; flag_z_in = c[1];
                #0.5;
                check("R4 flag not early", W'(flag_c), W'(mc[l-1]));
                tick();
                flag_we = 0;
                mc[l-1] = c[0]; mz[l-1] = c[1];
                check("R4 flag C", W'(flag_c), W'(c[0]));
                check("R4 flag Z", W'(flag_z), W'(c[1]));
            end
        end
        // R5: distinct pair per level, then revisit all
        for (int l = 1; l <= 5; l++) begin
            act_lvl = 3'(l); flag_we = 1;
            flag_c_in = l[0]; flag_z_in = l[1];
            tick();
            flag_we = 0;
            mc[l-1] = l[0]; mz[l-1] = l[1];
        end
        repeat (2) tick();
        check_flags("R5 per level");

        // R10: invalid levels read zero and write nothing
        foreach (mc[j]) begin end
        for (int b = 0; b < 3; b++) begin
            act_lvl = (b == 0) ? 3'd0 : 3'(b + 5);
            #0.5;
            for (int k = 0; k < G; k++) check("R10 bad lvl read", wk_rdata[k*W +: W], '0);
            check("R10 bad lvl iar", iar_q, '0);
            check("R10 bad lvl C", W'(flag_c), '0);
            wk_we = 1; wk_idx = 3'(b); wk_wdata = '1;
            flag_we = 1; flag_c_in = 1; flag_z_in = 1;
            tick();
            idle();
        end
        read_all("R10 no reg write");
        check_flags("R10 no flag write");

        // R11: unmapped external addresses
        for (int a = N; a < 64; a++) begin
            ext_we = 1; ext_addr = 6'(a); ext_wdata = '1;
            #0.5;
            check("R11 unmapped read", ext_rdata, '0);
            tick();
        end
        idle();
        read_all("R11 no write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule